// File: doc/BRIEF.md
# Non-volatile configuration load sequencer

This block runs the start-up load of an embedded flash controller. When reset is released it walks a fixed list of special non-volatile locations. It reads each one through a memory-read port that returns the data word and a two-bit ECC status. It then copies the word into the volatile register that the list assigns to that location. The list is a parameter table: location `i` sits at address `ADDR_BASE + i*ADDR_STEP` and loads shadow register `N_LOC-1-i`. Every third entry, starting with entry 0, is a system location, and all other entries are user locations.

An uncorrectable (double) ECC error is handled according to the class of the failing location. On a system location the load stops at once and raises a fatal flag. On a user location the target register is filled with all ones, and the load carries on to the end with the good-completion bit cleared. A corrected (single) error counts as a good read.

The block also holds a 32-bit control/status register with MSB-first bit numbering. It contains the error flags, which are cleared by writing 1, the read-only size and status fields, and five read/write control bits.

Top module: `nv_cfg_loader`

## Requirements
- R1: Exactly one of `busy_o`, `done_o` and `fatal_o` is high at any time. `busy_o` is high from reset until the last location is accepted or a fatal abort happens. After that, `done_o` marks a normal end and `fatal_o` marks an abort.
- R2: Reads are issued in table order, one accepted read per location, at address `ADDR_BASE + i*ADDR_STEP`. The address is held while `rd_req_o` waits for `rd_valid_i`.
- R3: A read with ECC status 0 (clean) or 1 (corrected) loads its data into shadow register `N_LOC-1-i`, which appears at `cfg_o[(N_LOC-1-i)*DATA_W +: DATA_W]`.
- R4: A read with ECC status 2 or 3 (double error) on a user location loads all ones into its register, and the load continues.
- R5: A user-location double error clears the good-completion bit (MSB-first bit 22, LSB bit 9) and sets the ECC-error flag (MSB-first bit 16, LSB bit 15).
- R6: A system-location double error ends the load with `fatal_o` high and sets the ECC-error flag. No read is issued and no register is written afterwards, so the registers of later locations keep their reset value.
- R7: A corrected read sets the ECC-event flag (MSB-first bit 0, LSB bit 31).
- R8: The register resets to 0x0220_0600 when `ARRAY_ID` is 0 and to 0x0210_0600 when `ARRAY_ID` is 1. In both cases the done bit (MSB-first bit 21) and the good-completion bit are 1.
- R9: Writing 1 to a clear-on-write flag (LSB bits 31, 15, 14) clears it. Writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R10: LSB bits 4..0 are read/write and reset to 0. Writes to every other bit are ignored.
- R11: All shadow registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_req_o | output | 1 | Read request, held until data is returned |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid; completes the pending request |
| rd_data_i | input | DATA_W | Read data |
| rd_ecc_i | input | 2 | ECC status: 0 clean, 1 corrected, 2/3 double |
| csr_we_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read value |
| cfg_o | output | N_LOC*DATA_W | Shadow registers, register j at bits j*DATA_W |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished without abort |
| fatal_o | output | 1 | Load aborted on a system-location double error |

## Verification
The bench runs one load for each pair of location and ECC code, and read latency varies from read to read. This exposes a design that mixes up the class map, treats code 3 as clean, or keeps reading after a system error: such a design would show extra read addresses or loaded registers past the abort point. User double errors must still produce all the remaining loads and a cleared good-completion bit. A design that aborted would show zeros in those registers, and a design that ignored the error would show raw data instead of all ones. The register sweep writes 0, single ones and all ones. It catches clear-on-write flags that clear on a 0, read-only bits that accept writes, and a wrong reset image for either array identity.

// File: rtl/nvl_pkg.sv
package nvl_pkg;
  typedef enum logic [1:0] {ST_LOAD, ST_DONE, ST_FATAL} nvl_state_e;

  // LSB positions of MSB-first register bits
  localparam int unsigned B_EDC  = 31;
  localparam int unsigned B_SIZE = 26;
  localparam int unsigned B_LAS  = 22;
  localparam int unsigned B_EER  = 15;
  localparam int unsigned B_RWE  = 14;
  localparam int unsigned B_DONE = 10;
  localparam int unsigned B_PEG  = 9;
  localparam int unsigned RW_W   = 5;

  // system class on every third entry
  function automatic logic [63:0] sys_map_f(int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < n && (i % 3) == 0) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/nvl_seq.sv
module nvl_seq #(
  parameter int N_LOC = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 'h40,
  parameter logic [ADDR_W-1:0] ADDR_STEP = 'h4,
  localparam int IDX_W = (N_LOC > 1) ? $clog2(N_LOC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [1:0]        rd_ecc_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ev_corr_o,
  output logic              ev_dbl_o,
  output logic              ev_user_dbl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fatal_o
);
  import nvl_pkg::*;

  localparam logic [63:0] SYS_ALL = sys_map_f(N_LOC);
  localparam logic [N_LOC-1:0] SYS_MAP = SYS_ALL[N_LOC-1:0];
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LOC - 1);

  nvl_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic acc, dbl, is_sys;

  assign acc    = (state_q == ST_LOAD) && rd_valid_i;
  assign dbl    = rd_ecc_i[1];
  assign is_sys = SYS_MAP[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      idx_q   <= '0;
    end else if (acc) begin
      if (dbl && is_sys)      state_q <= ST_FATAL;
      else if (idx_q == LAST) state_q <= ST_DONE;
      else                    idx_q   <= idx_q + 1'b1;
    end
  end

  assign rd_req_o  = (state_q == ST_LOAD);
  assign rd_addr_o = ADDR_BASE + ADDR_W'(idx_q) * ADDR_STEP;

  assign wr_en_o   = acc && !(dbl && is_sys);
  assign wr_idx_o  = LAST - idx_q;
  assign wr_data_o = dbl ? '1 : rd_data_i;

  assign ev_corr_o     = acc && (rd_ecc_i == 2'b01);
  assign ev_dbl_o      = acc && dbl;
  assign ev_user_dbl_o = acc && dbl && !is_sys;

  assign busy_o  = (state_q == ST_LOAD);
  assign done_o  = (state_q == ST_DONE);
  assign fatal_o = (state_q == ST_FATAL);

  // R1
  one_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({busy_o, done_o, fatal_o}) == 1);
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  // R6
  sys_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_valid_i && ev_dbl_o && !ev_user_dbl_o |=> fatal_o && !rd_req_o);
  // R6
  no_wr_after_fatal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !wr_en_o && !rd_req_o);
endmodule

// File: rtl/nvl_bank.sv
module nvl_bank #(
  parameter int N_LOC = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_LOC > 1) ? $clog2(N_LOC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic [N_LOC*DATA_W-1:0] cfg_o
);
  for (genvar j = 0; j < N_LOC; j++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(j))      q <= wr_data_i;
    end
    assign cfg_o[j*DATA_W +: DATA_W] = q;

    // R11
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_idx_i == IDX_W'(j)) |=> $stable(cfg_o[j*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/nvl_csr.sv
module nvl_csr #(
  parameter bit ARRAY_ID = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        ev_corr_i,
  input  logic        ev_dbl_i,
  input  logic        ev_user_dbl_i,
  output logic [31:0] rdata_o
);
  import nvl_pkg::*;

  localparam logic [2:0] SIZE_CODE = 3'b010;
  localparam logic [2:0] LAS_CODE  = ARRAY_ID ? 3'b001 : 3'b010;

  logic edc_q, eer_q, rwe_q, peg_q;
  logic [RW_W-1:0] rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edc_q <= 1'b0;
      eer_q <= 1'b0;
      rwe_q <= 1'b0;
      peg_q <= 1'b1;
      rw_q  <= '0;
    end else begin
      if (ev_corr_i)                  edc_q <= 1'b1;
      else if (we_i && wdata_i[B_EDC]) edc_q <= 1'b0;
      if (ev_dbl_i)                   eer_q <= 1'b1;
      else if (we_i && wdata_i[B_EER]) eer_q <= 1'b0;
      // no read-while-write source during load
      if (we_i && wdata_i[B_RWE])     rwe_q <= 1'b0;
      if (ev_user_dbl_i)              peg_q <= 1'b0;
      if (we_i)                       rw_q  <= wdata_i[RW_W-1:0];
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[B_EDC]            = edc_q;
    rdata_o[B_SIZE -: 3]      = SIZE_CODE;
    rdata_o[B_LAS -: 3]       = LAS_CODE;
    rdata_o[B_EER]            = eer_q;
    rdata_o[B_RWE]            = rwe_q;
    rdata_o[B_DONE]           = 1'b1;
    rdata_o[B_PEG]            = peg_q;
    rdata_o[RW_W-1:0]         = rw_q;
  end

  // R9
  rc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i[B_EDC] && !ev_corr_i |=> !rdata_o[B_EDC]);
  // R9
  rc_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !wdata_i[B_EER] |=> rdata_o[B_EER] || !$past(rdata_o[B_EER]));
  // R7
  edc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_corr_i |=> rdata_o[B_EDC]);
  // R5
  peg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_user_dbl_i |=> !rdata_o[B_PEG] && rdata_o[B_EER]);
  // R10
  rw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[RW_W-1:0] == $past(wdata_i[RW_W-1:0]));
endmodule

// File: rtl/nv_cfg_loader.sv
module nv_cfg_loader #(
  parameter int N_LOC = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 'h40,
  parameter logic [ADDR_W-1:0] ADDR_STEP = 'h4,
  parameter bit ARRAY_ID = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic                    rd_valid_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  input  logic [1:0]              rd_ecc_i,
  input  logic                    csr_we_i,
  input  logic [31:0]             csr_wdata_i,
  output logic [31:0]             csr_rdata_o,
  output logic [N_LOC*DATA_W-1:0] cfg_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fatal_o
);
  localparam int IDX_W = (N_LOC > 1) ? $clog2(N_LOC) : 1;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic ev_corr, ev_dbl, ev_user_dbl;

  nvl_seq #(
    .N_LOC(N_LOC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_BASE(ADDR_BASE), .ADDR_STEP(ADDR_STEP)
  ) u_seq (
    .clk_i, .rst_ni,
    .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i, .rd_ecc_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .ev_corr_o(ev_corr), .ev_dbl_o(ev_dbl), .ev_user_dbl_o(ev_user_dbl),
    .busy_o, .done_o, .fatal_o
  );

  nvl_bank #(.N_LOC(N_LOC), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .cfg_o
  );

  nvl_csr #(.ARRAY_ID(ARRAY_ID)) u_csr (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .wdata_i(csr_wdata_i),
    .ev_corr_i(ev_corr), .ev_dbl_i(ev_dbl), .ev_user_dbl_i(ev_user_dbl),
    .rdata_o(csr_rdata_o)
  );

  // R4
  user_dbl_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_user_dbl |=> !fatal_o);
  // R4
  user_dbl_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_user_dbl |=> cfg_o[$past(wr_idx)*DATA_W +: DATA_W] == '1);
endmodule

// File: tb/test_nv_cfg_loader.sv
module test_nv_cfg_loader;
  localparam int N = 6;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [31:0] RST0 = 32'h0220_0600;
  localparam logic [31:0] RST1 = 32'h0210_0600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic [1:0] rd_ecc = 2'b00;
  logic csr_we = 1'b0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [N*DW-1:0] cfg;
  logic busy, done, fatal;

  logic b_req, b_busy, b_done, b_fatal;
  logic [AW-1:0] b_addr;
  logic [31:0] b_rdata;
  logic [N*DW-1:0] b_cfg;

  always #4 clk = ~clk;

  nv_cfg_loader #(.N_LOC(N), .ADDR_W(AW), .DATA_W(DW)) i_nv_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_ecc_i(rd_ecc),
    .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .cfg_o(cfg), .busy_o(busy), .done_o(done), .fatal_o(fatal));

  nv_cfg_loader #(.N_LOC(N), .ADDR_W(AW), .DATA_W(DW), .ARRAY_ID(1'b1)) i_nv_cfg_loader_alt (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_o(b_req), .rd_addr_o(b_addr),
    .rd_valid_i(1'b0), .rd_data_i('0), .rd_ecc_i(2'b00),
    .csr_we_i(1'b0), .csr_wdata_i('0), .csr_rdata_o(b_rdata),
    .cfg_o(b_cfg), .busy_o(b_busy), .done_o(b_done), .fatal_o(b_fatal));

  int n_chk = 0, n_bad = 0;
  int ecc_pat [N];
  logic [AW-1:0] rd_log [16];
  int rd_cnt = 0;
  int wait_cnt = 0;
  int run_id = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] dat(logic [AW-1:0] a);
    return {a, ~a, a ^ 8'h5a, 8'hc3};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s run %0d: actual %h expected %h", tag, run_id, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rst_n && rd_req) begin
        if (wait_cnt == 0) begin
          int li;
          li = (int'(rd_addr) - 'h40) / 4;
          if (rd_cnt < 16) rd_log[rd_cnt] = rd_addr;
          rd_data  = dat(rd_addr);
          rd_ecc   = (li >= 0 && li < N) ? 2'(ecc_pat[li]) : 2'b00;
          rd_valid = 1'b1;
          rd_cnt++;
          wait_cnt = (rd_cnt + run_id) % 3;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic do_run();
    int abort_at, exp_reads;
    logic [31:0] exp_csr;
    logic [DW-1:0] exp_reg [N];
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_cnt = 0;
    wait_cnt = 0;
    // R8 R11
    chk("R8", 64'(csr_rdata), 64'(RST0));
    chk("R11", 64'(cfg == '0), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", 64'({busy, done, fatal}), 64'b100);
    for (int t = 0; t < 200 && busy; t++) @(negedge clk);

    abort_at = -1;
    exp_csr = RST0;
    for (int i = 0; i < N; i++) exp_reg[i] = '0;
    for (int i = 0; i < N; i++) begin
      if (abort_at >= 0) break;
      if (ecc_pat[i] >= 2) begin
        exp_csr[15] = 1'b1;
        if (i % 3 == 0) abort_at = i;
        else begin exp_reg[N-1-i] = '1; exp_csr[9] = 1'b0; end
      end else begin
        exp_reg[N-1-i] = dat(AW'('h40 + 4*i));
        if (ecc_pat[i] == 1) exp_csr[31] = 1'b1;
      end
    end
    exp_reads = (abort_at >= 0) ? abort_at + 1 : N;

    // R1 R6
    chk(abort_at >= 0 ? "R6" : "R1", 64'({busy, done, fatal}),
        abort_at >= 0 ? 64'b001 : 64'b010);
    // R2
    chk("R2", 64'(rd_cnt), 64'(exp_reads));
    for (int i = 0; i < exp_reads && i < 16; i++)
      chk("R2", 64'(rd_log[i]), 64'('h40 + 4*i));
    // R3 R4 R6
    for (int j = 0; j < N; j++)
      chk(abort_at >= 0 ? "R6" : (exp_reg[j] == '1 ? "R4" : "R3"),
          64'(cfg[j*DW +: DW]), 64'(exp_reg[j]));
    // R5 R7
    chk(exp_csr[9] ? "R7" : "R5", 64'(csr_rdata), 64'(exp_csr));
    run_id++;
  endtask

  task automatic csr_wr(logic [31:0] v);
    @(negedge clk);
    csr_wdata = v;
    csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) ecc_pat[i] = 0;
    repeat (2) @(negedge clk);
    // R8
    chk("R8", 64'(b_rdata), 64'(RST1));

    for (int k = 0; k < N; k++)
      for (int c = 0; c < 4; c++) begin
        for (int i = 0; i < N; i++) ecc_pat[i] = 0;
        ecc_pat[k] = c;
        do_run();
      end

    // mixed pattern, then register access sweep
    ecc_pat[0] = 0; ecc_pat[1] = 2; ecc_pat[2] = 1;
    ecc_pat[3] = 0; ecc_pat[4] = 3; ecc_pat[5] = 1;
    do_run();
    // R9 zero write keeps flags
    csr_wr(32'h0);
    chk("R9", 64'(csr_rdata), 64'(32'h8220_8400));
    // R9 clear only the event flag
    csr_wr(32'h8000_0000);
    chk("R9", 64'(csr_rdata), 64'(32'h0220_8400));
    // R10 R9 all ones: rw bits take it, read-only bits hold, error flag clears
    csr_wr(32'hFFFF_FFFF);
    chk("R10", 64'(csr_rdata), 64'(32'h0220_041F));
    csr_wr(32'h0000_0015);
    chk("R10", 64'(csr_rdata), 64'(32'h0220_0415));
    // R10 read-only region ignores writes
    csr_wr(32'h7DDF_39E0);
    chk("R10", 64'(csr_rdata), 64'(32'h0220_0400));
    // R1 state held after the load
    chk("R1", 64'({busy, done, fatal}), 64'b010);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule